// File: doc/BRIEF.md
# Debug Transaction Completion Checker

This block is a hardware sequencer on the host side of a scan-based debug link. After a batch of queued debug-port accesses, a one-cycle pulse on `chk_start` makes it confirm that the batch has finished. It reads the debug port's status register as a posted read and then collects that value from the read buffer. It keeps polling while the target answers WAIT, up to a millisecond budget, and sends an abort scan if the budget runs out. Once it has a valid status word, it checks the sticky overrun and sticky error flags. If the debug power domains still read as powered, it clears those flags. The block ends every run with a one-cycle `done` pulse and a status code.

The same sequencer also carries out single access-port reads and writes, started by `ap_start`. Before such an access it writes the bank-select register, but only when the register bank differs from the one it last programmed. Each scan goes to an external scan engine as a one-cycle request. The engine answers with `rsp_valid`, a 3-bit acknowledge and the 32-bit word it shifted out. The millisecond timer is a prescaled cycle counter whose length comes from the `CLK_HZ` parameter.

Top module: `dbg_txn_checker`

## Requirements
- R1: On `chk_start`, the block issues a scan with instruction 0xA, address 1 (status register) and read direction. After that scan's response it issues a scan with instruction 0xA, address 3 (read buffer) and read direction. Every request is a single-cycle `req_valid` pulse, and no new request appears before `rsp_valid` answers the previous one.
- R2: The read-buffer acknowledge is taken on 3 bits, and 2 means proceed. A status word with bit 1 (sticky overrun) and bit 5 (sticky error) both clear ends the run with status 0, and `rd_data` holds the word.
- R3: Acknowledge 1 (WAIT) repeats the status/read-buffer pair. Any acknowledge other than 1 or 2 ends the run with status 2 and issues no further scan.
- R4: If WAIT arrives after more than `TIMEOUT_MS` milliseconds have passed since the start, the block issues an abort scan: instruction 0x8, address 0, write direction, data 1. After that it ends with status 1. One millisecond equals `CLK_HZ/1000` clock cycles.
- R5: If either sticky bit is set and status bits 31:28 are not all ones, the run ends with status 3 and no further scan.
- R6: If either sticky bit is set and bits 31:28 are all ones, the block writes address 1 with `ctrl_save | 0x22` (instruction 0xA, write direction). It then repeats the status/read-buffer pair and ends with status 4.
- R7: On `ap_start`, the first access after reset, or one whose `ap_reg[7:4]` differs from the last programmed bank, is preceded by a select write. That write uses instruction 0xA, address 2 and data `{ap_port, 16'h0, ap_reg[7:4], 4'h0}`. The access itself uses instruction 0xB, address `ap_reg[3:2]` and direction `ap_rnw`, carrying `ap_wdata` on a write. A read adds a read-buffer scan, and the run ends with status 0 and the read word in `rd_data`.
- R8: An access-port access whose bank equals the last programmed bank issues no select write.
- R9: After reset, `done`, `req_valid` and `status` are 0. `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chk_start | input | 1 | Start a completion check (pulse) |
| ctrl_save | input | 32 | Saved control value written back when clearing sticky flags |
| ap_start | input | 1 | Start an access-port access (pulse) |
| ap_reg | input | 8 | Access-port register address |
| ap_port | input | 8 | Current access-port number |
| ap_rnw | input | 1 | 1 = read, 0 = write |
| ap_wdata | input | 32 | Write data for the access-port write |
| req_valid | output | 1 | Scan request pulse |
| req_instr | output | 4 | Scan instruction |
| req_addr | output | 2 | Register address bits 3:2 |
| req_rnw | output | 1 | Scan direction, 1 = read |
| req_wdata | output | 32 | Scan data shifted in |
| rsp_valid | input | 1 | Scan response strobe |
| rsp_ack | input | 3 | Acknowledge of the scan |
| rsp_data | input | 32 | Word shifted out by the scan |
| done | output | 1 | Run finished (one cycle) |
| status | output | 3 | 0 ok, 1 timeout, 2 bad ack, 3 unpowered, 4 sticky cleared |
| rd_data | output | 32 | Last word collected from the read buffer |

## Verification
The bench goes after the decisions taken on the read-buffer acknowledge. A design that treats an unknown acknowledge as WAIT would poll until the timeout instead of reporting status 2. A design that skips the repeat on WAIT would finish with status 0 on a stale word. For the timeout, a design that aborts early shows up through the measured elapsed cycles, and a wrong abort payload shows up through the scan compare. On the sticky path, a design that clears without checking the power bits would emit a write where none is expected. A wrong mask would show up as a mismatch in the write-back data. For bank selection, a design that always writes the select register, or compares the wrong address bits, shows up as an extra scan or a missing one.

// File: rtl/dbg_txn_checker.sv
module dbg_txn_checker #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_MS = 1000,
  parameter int ORUN_BIT   = 1,
  parameter int SERR_BIT   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_start,
  input  logic [31:0] ctrl_save,
  input  logic        ap_start,
  input  logic [7:0]  ap_reg,
  input  logic [7:0]  ap_port,
  input  logic        ap_rnw,
  input  logic [31:0] ap_wdata,
  output logic        req_valid,
  output logic [3:0]  req_instr,
  output logic [1:0]  req_addr,
  output logic        req_rnw,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [2:0]  rsp_ack,
  input  logic [31:0] rsp_data,
  output logic        done,
  output logic [2:0]  status,
  output logic [31:0] rd_data
);
  localparam int TICKS = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 2;
  localparam int PRE_W = $clog2(TICKS);
  localparam int MS_W  = $clog2(TIMEOUT_MS + 2);
  localparam logic [31:0] STK_MASK = (32'd1 << ORUN_BIT) | (32'd1 << SERR_BIT);
  localparam logic [3:0] I_DP = 4'hA, I_AP = 4'hB, I_ABT = 4'h8;
  localparam logic [2:0] ACK_OK = 3'd2, ACK_WAIT = 3'd1;
  localparam logic [2:0] S_OK = 3'd0, S_TMO = 3'd1, S_BADACK = 3'd2,
                         S_NOPWR = 3'd3, S_STICKY = 3'd4;

  typedef enum logic [3:0] {
    P_CS, P_RB, P_CLW, P_CLR, P_CLB, P_ABT, P_SEL, P_APA, P_APB
  } phase_t;

  phase_t      phase, nxt;
  logic        busy, issue, fin;
  logic [2:0]  fin_code;
  logic [31:0] ctrl_q, wdata_q;
  logic [7:0]  reg_q, port_q;
  logic        rnw_q;
  logic [3:0]  bank_q;
  logic        bank_ok;
  logic [PRE_W-1:0] pre_cnt;
  logic [MS_W-1:0]  ms_cnt;
  logic        timed_out;

  assign timed_out = ms_cnt > MS_W'(TIMEOUT_MS);
  assign req_valid = busy & issue;

  always_comb begin
    req_instr = I_DP;
    req_addr  = 2'd0;
    req_rnw   = 1'b1;
    req_wdata = 32'd0;
    case (phase)
      P_CS, P_CLR: req_addr = 2'd1;
      P_RB, P_CLB, P_APB: req_addr = 2'd3;
      P_CLW: begin
        req_addr  = 2'd1;
        req_rnw   = 1'b0;
        req_wdata = ctrl_q | STK_MASK;
      end
      P_ABT: begin
        req_instr = I_ABT;
        req_rnw   = 1'b0;
        req_wdata = 32'd1;
      end
      P_SEL: begin
        req_addr  = 2'd2;
        req_rnw   = 1'b0;
        req_wdata = {port_q, 16'h0, reg_q[7:4], 4'h0};
      end
      P_APA: begin
        req_instr = I_AP;
        req_addr  = reg_q[3:2];
        req_rnw   = rnw_q;
        req_wdata = rnw_q ? 32'd0 : wdata_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt      = phase;
    fin      = 1'b0;
    fin_code = S_OK;
    case (phase)
      P_CS:  nxt = P_RB;
      P_RB:
        if (rsp_ack == ACK_OK) begin
          if ((rsp_data & STK_MASK) != 32'd0) begin
            if (rsp_data[31:28] != 4'hF) begin
              fin = 1'b1; fin_code = S_NOPWR;
            end else nxt = P_CLW;
          end else fin = 1'b1;
        end else if (rsp_ack == ACK_WAIT) begin
          nxt = timed_out ? P_ABT : P_CS;
        end else begin
          fin = 1'b1; fin_code = S_BADACK;
        end
      P_CLW: nxt = P_CLR;
      P_CLR: nxt = P_CLB;
      P_CLB: begin fin = 1'b1; fin_code = S_STICKY; end
      P_ABT: begin fin = 1'b1; fin_code = S_TMO; end
      P_SEL: nxt = P_APA;
      P_APA: if (rnw_q) nxt = P_APB; else fin = 1'b1;
      default: fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_CS;
      busy    <= 1'b0;
      issue   <= 1'b0;
      done    <= 1'b0;
      status  <= S_OK;
      rd_data <= 32'd0;
      ctrl_q  <= 32'd0;
      wdata_q <= 32'd0;
      reg_q   <= 8'd0;
      port_q  <= 8'd0;
      rnw_q   <= 1'b0;
      bank_q  <= 4'd0;
      bank_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (chk_start) begin
          busy   <= 1'b1;
          issue  <= 1'b1;
          phase  <= P_CS;
          ctrl_q <= ctrl_save;
        end else if (ap_start) begin
          busy    <= 1'b1;
          issue   <= 1'b1;
          reg_q   <= ap_reg;
          port_q  <= ap_port;
          rnw_q   <= ap_rnw;
          wdata_q <= ap_wdata;
          if (!bank_ok || ap_reg[7:4] != bank_q) begin
            phase   <= P_SEL;
            bank_q  <= ap_reg[7:4];
            bank_ok <= 1'b1;
          end else phase <= P_APA;
        end
      end else if (issue) begin
        issue <= 1'b0;
      end else if (rsp_valid) begin
        if (phase == P_RB || phase == P_CLB || phase == P_APB) rd_data <= rsp_data;
        if (fin) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          status <= fin_code;
        end else begin
          issue <= 1'b1;
          phase <= nxt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (!busy && chk_start) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (busy && !timed_out) begin
      if (pre_cnt == PRE_W'(TICKS - 1)) begin
        pre_cnt <= '0;
        ms_cnt  <= ms_cnt + 1'b1;
      end else pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !issue && rsp_valid && phase == P_RB && rsp_ack != ACK_OK && rsp_ack != ACK_WAIT)
    |=> (done && status == S_BADACK)); // R3
  AST_ABORT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_instr == I_ABT) |-> timed_out); // R4
  AST_TMO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == S_TMO) |-> timed_out); // R4
  AST_NOPWR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == S_NOPWR) |-> (rd_data[31:28] != 4'hF && (rd_data & STK_MASK) != 32'd0)); // R5
  AST_BANK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_instr == I_AP) |-> (bank_ok && bank_q == reg_q[7:4])); // R7
endmodule

// File: tb/sim_dbg_txn_checker.sv
module sim_dbg_txn_checker;
  localparam int CLK_HZ = 10_000;
  localparam int TMO_MS = 4;
  localparam int TICKS  = CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_start = 1'b0;
  logic [31:0] ctrl_save = 32'h5000_0000;
  logic        ap_start = 1'b0;
  logic [7:0]  ap_reg = 8'd0;
  logic [7:0]  ap_port = 8'd0;
  logic        ap_rnw = 1'b0;
  logic [31:0] ap_wdata = 32'd0;
  logic        req_valid;
  logic [3:0]  req_instr;
  logic [1:0]  req_addr;
  logic        req_rnw;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_ack = 3'd0;
  logic [31:0] rsp_data = 32'd0;
  logic        done;
  logic [2:0]  status;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  dbg_txn_checker #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .chk_start(chk_start), .ctrl_save(ctrl_save),
    .ap_start(ap_start), .ap_reg(ap_reg), .ap_port(ap_port), .ap_rnw(ap_rnw),
    .ap_wdata(ap_wdata), .req_valid(req_valid), .req_instr(req_instr),
    .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
    .done(done), .status(status), .rd_data(rd_data));

  int vectors = 0;
  int fails = 0;
  string tag = "R9";
  logic [38:0] expq[$];
  logic [34:0] rspq[$];
  bit wait_mode = 1'b0;
  int wait_scans = 0;
  int abort_seen = 0;

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic exp_scan(input logic [3:0] i, input logic [1:0] a, input logic r,
                          input logic [31:0] w, input logic [2:0] k, input logic [31:0] d);
    expq.push_back({i, a, r, w});
    rspq.push_back({k, d});
  endtask

  initial begin : monitor
    logic [38:0] got;
    logic [38:0] e;
    logic [34:0] r;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_valid) begin
        got = {req_instr, req_addr, req_rnw, req_wdata};
        r = {3'd2, 32'd0};
        if (wait_mode) begin
          if (req_instr == 4'h8) begin
            abort_seen++;
            chk(got == {4'h8, 2'd0, 1'b0, 32'd1}, "R4 abort scan", 64'(got), 64'({4'h8, 2'd0, 1'b0, 32'd1}));
          end else begin
            wait_scans++;
            r = {3'd1, 32'd0};
          end
        end else if (expq.size() == 0) begin
          chk(1'b0, {tag, " unexpected scan"}, 64'(got), 64'd0);
        end else begin
          e = expq.pop_front();
          r = rspq.pop_front();
          chk(got == e, {tag, " scan request"}, 64'(got), 64'(e));
        end
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_ack   = r[34:32];
        rsp_data  = r[31:0];
      end
    end
  end

  task automatic run(input bit is_ap, input logic [2:0] exp_st, input bit chk_rd,
                     input logic [31:0] exp_rd, output int cycles);
    @(negedge clk);
    if (is_ap) ap_start = 1'b1; else chk_start = 1'b1;
    @(negedge clk);
    ap_start = 1'b0;
    chk_start = 1'b0;
    cycles = 1;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    chk(done, {tag, " done seen"}, 64'(done), 64'd1);
    chk(status == exp_st, {tag, " status"}, 64'(status), 64'(exp_st));
    if (chk_rd) chk(rd_data == exp_rd, {tag, " rd_data"}, 64'(rd_data), 64'(exp_rd));
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, {tag, " all scans issued"}, 64'(expq.size()), 64'd0);
    expq.delete();
    rspq.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : driver
    int cyc;
    repeat (3) @(negedge clk);
    chk(!done && !req_valid && status == 3'd0, "R9 reset state", 64'({done, req_valid, status}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R1 R2 clean";
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'hF000_0000);
    run(1'b0, 3'd0, 1'b1, 32'hF000_0000, cyc);

    tag = "R3 wait then ok";
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd1, 32'h0);
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd1, 32'h0);
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'hF000_0400);
    run(1'b0, 3'd0, 1'b1, 32'hF000_0400, cyc);

    tag = "R3 bad ack";
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd4, 32'h0);
    run(1'b0, 3'd2, 1'b0, 32'd0, cyc);

    tag = "R6 sticky clear";
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'hF000_0020);
    exp_scan(4'hA, 2'd1, 1'b0, 32'h5000_0022, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'hF000_0000);
    run(1'b0, 3'd4, 1'b1, 32'hF000_0000, cyc);

    tag = "R5 unpowered";
    exp_scan(4'hA, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'h7000_0002);
    run(1'b0, 3'd3, 1'b1, 32'h7000_0002, cyc);

    tag = "R4 timeout";
    wait_mode = 1'b1;
    run(1'b0, 3'd1, 1'b0, 32'd0, cyc);
    wait_mode = 1'b0;
    chk(abort_seen == 1, "R4 one abort", 64'(abort_seen), 64'd1);
    chk(cyc >= (TMO_MS + 1) * TICKS, "R4 not before budget", 64'(cyc), 64'((TMO_MS + 1) * TICKS));
    chk(wait_scans % 2 == 0 && wait_scans >= 4, "R3 WAIT repeats pair", 64'(wait_scans), 64'd4);

    tag = "R7 ap read new bank";
    ap_reg = 8'h14; ap_port = 8'h02; ap_rnw = 1'b1; ap_wdata = 32'hFFFF_FFFF;
    exp_scan(4'hA, 2'd2, 1'b0, 32'h0200_0010, 3'd2, 32'h0);
    exp_scan(4'hB, 2'd1, 1'b1, 32'd0, 3'd2, 32'h0);
    exp_scan(4'hA, 2'd3, 1'b1, 32'd0, 3'd2, 32'hCAFE_0001);
    run(1'b1, 3'd0, 1'b1, 32'hCAFE_0001, cyc);

    tag = "R8 ap write same bank";
    ap_reg = 8'h18; ap_rnw = 1'b0; ap_wdata = 32'h1234_5678;
    exp_scan(4'hB, 2'd2, 1'b0, 32'h1234_5678, 3'd2, 32'h0);
    run(1'b1, 3'd0, 1'b0, 32'd0, cyc);

    tag = "R7 ap write bank change";
    ap_reg = 8'h24; ap_wdata = 32'h0000_00A5;
    exp_scan(4'hA, 2'd2, 1'b0, 32'h0200_0020, 3'd2, 32'h0);
    exp_scan(4'hB, 2'd1, 1'b0, 32'h0000_00A5, 3'd2, 32'h0);
    run(1'b1, 3'd0, 1'b0, 32'd0, cyc);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule